// File: doc/BRIEF.md
# Four-Channel Direct Memory Access Engine

This block moves data between memory, memory-mapped devices and request-driven peripherals without the CPU. Four independent channels each hold a source address, a destination address, a unit count and a control word. Software loads these through a small write-only register port. The engine masters one shared bus through a request/grant pair. It drives a 32-bit address, read and write strobes, a byte-or-word size signal and a 16-bit write data path, and it takes 16-bit read data back.

Each channel has a level-sensitive request input and an acknowledge output. A channel moves one unit each time it wins arbitration while it is enabled and its request is high.

In dual-address mode, which every channel supports, a unit is a read cycle followed by a write cycle that carries the data just read. In single-address mode, which only the two lowest channels support, a unit is one bus cycle. In that mode the acknowledge line selects the peripheral and the address bus selects the memory side. When a channel's count runs out, the channel disables itself and raises a sticky completion flag, which can drive the interrupt.

Top module: `dma4_engine`

## Requirements
- R1: Register writes use `reg_addr = {channel[1:0], sel[1:0]}`, where sel 0 is the source address, 1 the destination address, 2 the count (low CNT_W bits) and 3 the control word. Control bits: 0 enable, 1 word unit, 2 single-address mode, 3 peripheral-is-source, [5:4] source step mode, [7:6] destination step mode, 8 interrupt enable.
- R2: In dual-address mode, each unit is a read cycle at the source address. It is followed in the very next clock by a write cycle at the destination address, whose `bus_wdata` equals the `bus_rdata` returned by that read. `dack` stays low.
- R3: Single-address mode on channel 0 or 1 moves a unit in one bus cycle, with `dack[ch]` high for exactly that cycle. If control bit 3 is 0, the cycle is a read at the source address. If it is 1, the cycle is a write at the destination address.
- R4: Control bit 1 selects the unit size. When it is 1, `bus_word` is 1 and the address step is 2. When it is 0, `bus_word` is 0 and the step is 1.
- R5: After each unit, each address is updated according to its 2-bit mode: 01 adds the step, 10 subtracts the step, and 00 or 11 leaves it unchanged.
- R6: A channel performs exactly the programmed number of units. A count of zero means 2^CNT_W units, which is 65536 at the default width.
- R7: After the last unit, the channel clears its enable and sets `ch_done[ch]`. `irq` is high while any channel has both its done flag and its interrupt enable set. Writing a channel's control word clears its done and error flags.
- R8: When several enabled channels request at once, the lowest-numbered channel wins. Arbitration happens only between units, so a read/write pair always belongs to one channel.
- R9: Enabling single-address mode on channel 2 or 3 sets `ch_err[ch]`. That channel stays disabled: it makes no bus cycles and never sets its done flag.
- R10: `bus_rd` and `bus_wr` are never high together. They are asserted only while `bus_req` and `bus_gnt` are both high. No strobe appears that does not belong to a programmed unit.
- R11: After reset, `bus_req`, both strobes, `dack`, `ch_done`, `ch_err` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel and register select |
| reg_wdata | input | 32 | Register write data |
| dreq | input | 4 | Per-channel transfer request, level sensitive |
| dack | output | 4 | Per-channel acknowledge in single-address cycles |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | 32 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_word | output | 1 | 1 for a 16-bit unit, 0 for a byte |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled at the end of a read cycle |
| ch_done | output | 4 | Sticky completion flags |
| ch_err | output | 4 | Illegal-mode flags |
| irq | output | 1 | Interrupt |

## Verification
A unit's first strobe comes at least two clocks after the request is sampled: one clock to raise `bus_req`, then at least one clock to see the grant. A dual-address write follows its read exactly one clock later. The done flag appears two clocks after the final strobe begins. Because grant latency belongs to the bench, the reference model predicts the ordered list of bus cycles rather than their absolute times. On every falling edge where a strobe is high, the model compares the next predicted cycle field by field. Flags are polled with bounded waits after the last predicted cycle, and the ordering cases (priority and the read/write pairing) are checked against that same list.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  // control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_WORD = 1;
  localparam int CB_SGL  = 2;
  localparam int CB_SDIR = 3;
  localparam int CB_SM   = 4;
  localparam int CB_DM   = 6;
  localparam int CB_IE   = 8;

  // register selects
  localparam logic [1:0] RS_SRC  = 2'd0;
  localparam logic [1:0] RS_DST  = 2'd1;
  localparam logic [1:0] RS_CNT  = 2'd2;
  localparam logic [1:0] RS_CTRL = 2'd3;

  // address step modes
  localparam logic [1:0] AM_UP   = 2'b01;
  localparam logic [1:0] AM_DOWN = 2'b10;

  typedef enum logic [2:0] {
    XS_IDLE, XS_REQ, XS_CYC1, XS_CYC2, XS_UPD
  } xs_e;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CNT_W     = 16,
  parameter bit SINGLE_OK = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          unit_done,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          en,
  output logic          word,
  output logic          single,
  output logic          sdir,
  output logic          ie,
  output logic          done,
  output logic          err
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [1:0]       smode, dmode;
  logic [CNT_W-1:0] cnt;
  logic             bad_start;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a,
                                               input logic [1:0] m,
                                               input logic w);
    logic [AW-1:0] d;
    d = w ? AW'(2) : AW'(1);
    case (m)
      AM_UP:   return a + d;
      AM_DOWN: return a - d;
      default: return a;
    endcase
  endfunction

  assign bad_start = wr_data[CB_EN] & wr_data[CB_SGL] & !SINGLE_OK;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_addr <= '0;
      dst_addr <= '0;
      cnt      <= '0;
      en       <= 1'b0;
      word     <= 1'b0;
      single   <= 1'b0;
      sdir     <= 1'b0;
      ie       <= 1'b0;
      smode    <= '0;
      dmode    <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        RS_SRC: src_addr <= wr_data;
        RS_DST: dst_addr <= wr_data;
        RS_CNT: cnt      <= wr_data[CNT_W-1:0];
        default: begin
          word   <= wr_data[CB_WORD];
          single <= wr_data[CB_SGL] & SINGLE_OK;
          sdir   <= wr_data[CB_SDIR];
          smode  <= wr_data[CB_SM+1:CB_SM];
          dmode  <= wr_data[CB_DM+1:CB_DM];
          ie     <= wr_data[CB_IE];
          done   <= 1'b0;
          err    <= bad_start;
          en     <= wr_data[CB_EN] & !bad_start;
        end
      endcase
    end else if (unit_done) begin
      src_addr <= step_addr(src_addr, smode, word);
      dst_addr <= step_addr(dst_addr, dmode, word);
      cnt      <= cnt - CNT_ONE;
      if (cnt == CNT_ONE) begin
        en   <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  // fixed priority: lowest index wins
  always_comb begin
    idx = '0;
    any = |req;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dma4_xfer.sv
module dma4_xfer
  import dma4_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any,
  input  logic [IW-1:0] pick,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          word,
  input  logic          single,
  input  logic          sdir,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_word,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic [N-1:0]  dack,
  output logic [IW-1:0] cur,
  output logic          unit_done
);
  xs_e  st;
  logic sgl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= XS_IDLE;
      sgl_q     <= 1'b0;
      cur       <= '0;
      bus_req   <= 1'b0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_word  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      dack      <= '0;
    end else begin
      case (st)
        XS_IDLE: begin
          if (any) begin
            cur     <= pick;
            bus_req <= 1'b1;
            st      <= XS_REQ;
          end
        end
        XS_REQ: begin
          if (bus_gnt) begin
            bus_word  <= word;
            sgl_q     <= single;
            bus_wdata <= '0;
            if (single) begin
              dack <= N'(1) << cur;
              if (sdir) begin
                bus_wr   <= 1'b1;
                bus_addr <= dst;
              end else begin
                bus_rd   <= 1'b1;
                bus_addr <= src;
              end
            end else begin
              bus_rd   <= 1'b1;
              bus_addr <= src;
            end
            st <= XS_CYC1;
          end
        end
        XS_CYC1: begin
          if (sgl_q) begin
            bus_rd <= 1'b0;
            bus_wr <= 1'b0;
            dack   <= '0;
            st     <= XS_UPD;
          end else begin
            bus_rd    <= 1'b0;
            bus_wr    <= 1'b1;
            bus_addr  <= dst;
            bus_wdata <= bus_rdata;
            st        <= XS_CYC2;
          end
        end
        XS_CYC2: begin
          bus_wr <= 1'b0;
          st     <= XS_UPD;
        end
        XS_UPD: begin
          bus_req <= 1'b0;
          st      <= XS_IDLE;
        end
        default: st <= XS_IDLE;
      endcase
    end
  end

  assign unit_done = (st == XS_UPD);
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine #(
  parameter int N        = 4,
  parameter int AW       = 32,
  parameter int DW       = 16,
  parameter int CNT_W    = 16,
  parameter int SINGLE_N = 2,
  localparam int IW      = $clog2(N),
  localparam int RA_W    = IW + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [AW-1:0]   reg_wdata,
  input  logic [N-1:0]    dreq,
  output logic [N-1:0]    dack,
  output logic            bus_req,
  input  logic            bus_gnt,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic            bus_word,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  output logic [N-1:0]    ch_done,
  output logic [N-1:0]    ch_err,
  output logic            irq
);
  logic [AW-1:0] src_a [N];
  logic [AW-1:0] dst_a [N];
  logic [N-1:0]  en, word, single, sdir, ie;
  logic [IW-1:0] pick, cur;
  logic          any, unit_done;

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic hit;
    assign hit = reg_we && (reg_addr[RA_W-1:2] == IW'(i));
    dma4_chan #(
      .AW(AW), .CNT_W(CNT_W), .SINGLE_OK(i < SINGLE_N)
    ) u_chan (
      .clk(clk), .rst(rst),
      .wr_en(hit), .wr_sel(reg_addr[1:0]), .wr_data(reg_wdata),
      .unit_done(unit_done && (cur == IW'(i))),
      .src_addr(src_a[i]), .dst_addr(dst_a[i]),
      .en(en[i]), .word(word[i]), .single(single[i]), .sdir(sdir[i]),
      .ie(ie[i]), .done(ch_done[i]), .err(ch_err[i])
    );
  end

  dma4_arb #(.N(N), .IW(IW)) u_arb (
    .req(en & dreq), .idx(pick), .any(any)
  );

  dma4_xfer #(.N(N), .AW(AW), .DW(DW), .IW(IW)) u_xfer (
    .clk(clk), .rst(rst), .any(any), .pick(pick),
    .src(src_a[cur]), .dst(dst_a[cur]),
    .word(word[cur]), .single(single[cur]), .sdir(sdir[cur]),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .dack(dack), .cur(cur), .unit_done(unit_done)
  );

  assign irq = |(ch_done & ie);
endmodule

// File: rtl/dma4_engine_chk.sv
module dma4_engine_chk #(
  parameter int N        = 4,
  parameter int DW       = 16,
  parameter int SINGLE_N = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_we,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [DW-1:0] bus_rdata,
  input logic [DW-1:0] bus_wdata,
  input logic [N-1:0]  dack,
  input logic [N-1:0]  ch_done,
  input logic [N-1:0]  ch_err
);
  assert_rdwr_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  assert_strobe_granted_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> (bus_req && bus_gnt));

  assert_dack_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dack));

  assert_dack_in_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    (|dack) |-> (bus_rd || bus_wr));

  assert_dual_pair_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && !$past(|dack)) |-> (bus_wr && dack == '0));

  assert_dual_data_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && !$past(|dack)) |-> (bus_wdata == $past(bus_rdata)));

  assert_no_dack_high_R9: assert property (@(posedge clk) disable iff (rst)
    (dack >> SINGLE_N) == '0);

  assert_no_err_low_R9: assert property (@(posedge clk) disable iff (rst)
    ch_err[SINGLE_N-1:0] == '0);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (|($past(ch_done) & ~ch_done)) |-> $past(reg_we));
endmodule

bind dma4_engine dma4_engine_chk #(.N(N), .DW(DW), .SINGLE_N(SINGLE_N)) u_chk (.*);

// File: tb/dma4_engine_tb.sv
module dma4_engine_tb;
  localparam int CW = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack;
  logic        bus_req, bus_gnt, bus_rd, bus_wr, bus_word, irq;
  logic [31:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [3:0]  ch_done, ch_err;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] addr;
    logic        rd, wr, word, cdat;
    logic [3:0]  dack;
    logic [15:0] data;
    string       tag;
  } txn_t;
  txn_t expq[$];
  txn_t mon_t;

  always #4 clk = ~clk;

  dma4_engine #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dreq(dreq), .dack(dack), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_done(ch_done), .ch_err(ch_err), .irq(irq)
  );

  function automatic logic [15:0] mem_val(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[31:24], 8'h00};
  endfunction

  function automatic logic [31:0] adv(input logic [31:0] a, input logic [1:0] m,
                                      input logic w);
    int st = w ? 2 : 1;
    if (m == 2'b01) return a + st;
    if (m == 2'b10) return a - st;
    return a;
  endfunction

  // bus slave: grant one clock after request, read data from address
  always_ff @(posedge clk) bus_gnt <= rst ? 1'b0 : bus_req;
  assign bus_rdata = bus_rd ? mem_val(bus_addr) : 16'h0000;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference: predicted bus cycles per unit (R2 R3 R4 R5 R6)
  task automatic add_units(input int ch, input logic [31:0] s0, input logic [31:0] d0,
                           input int n, input logic [8:0] c, input string tag);
    logic [31:0] s = s0;
    logic [31:0] d = d0;
    for (int k = 0; k < n; k++) begin
      txn_t t;
      t.word = c[1];
      t.tag  = tag;
      if (c[2]) begin
        t.dack = 4'b0001 << ch;
        t.cdat = 1'b0;
        t.data = '0;
        t.rd   = !c[3];
        t.wr   = c[3];
        t.addr = c[3] ? d : s;
        expq.push_back(t);
      end else begin
        t.dack = 4'b0000;
        t.cdat = 1'b0;
        t.data = '0;
        t.rd = 1'b1; t.wr = 1'b0; t.addr = s;
        expq.push_back(t);
        t.rd = 1'b0; t.wr = 1'b1; t.addr = d;
        t.cdat = 1'b1; t.data = mem_val(s);
        expq.push_back(t);
      end
      s = adv(s, c[5:4], c[1]);
      d = adv(d, c[7:6], c[1]);
    end
  endtask

  // per-clock comparison of every bus cycle against the model
  always @(negedge clk) begin
    if (!rst && (bus_rd || bus_wr)) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R10", "unexpected bus cycle", {bus_addr, 1'b0, bus_rd, bus_wr}, 0);
      end else begin
        mon_t = expq.pop_front();
        chk({bus_addr, bus_rd, bus_wr, bus_word, dack} ==
            {mon_t.addr, mon_t.rd, mon_t.wr, mon_t.word, mon_t.dack},
            mon_t.tag, "bus cycle",
            {bus_addr, bus_rd, bus_wr, bus_word, dack},
            {mon_t.addr, mon_t.rd, mon_t.wr, mon_t.word, mon_t.dack});
        if (mon_t.cdat)
          chk(bus_wdata == mon_t.data, "R2", "write data", bus_wdata, mon_t.data);
      end
    end
  end

  task automatic wr(input int ch, input int sel, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {ch[1:0], sel[1:0]}; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d,
                      input int cnt, input logic [8:0] c);
    wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, cnt); wr(ch, 3, {23'd0, c});
  endtask

  task automatic wait_done(input int ch, input int lim, input string tag);
    int n = 0;
    while (!ch_done[ch] && n < lim) begin @(negedge clk); n++; end
    chk(ch_done[ch] == 1'b1, tag, "done flag", ch_done, 1 << ch);
    chk(expq.size() == 0, tag, "units left", expq.size(), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk({bus_req, bus_rd, bus_wr, dack, ch_done, ch_err, irq} == '0, "R11",
        "reset outputs", {bus_req, bus_rd, bus_wr, dack, ch_done, ch_err, irq}, 0);

    // R2 R4 R5 R7 R1: ch2 dual, word, both increment, irq enabled
    add_units(2, 32'h1000_0000, 32'h2000_0100, 3, 9'h153, "R2_R4_R5");
    prog(2, 32'h1000_0000, 32'h2000_0100, 3, 9'h153);
    dreq[2] = 1'b1;
    wait_done(2, 200, "R6");
    dreq[2] = 1'b0;
    chk(irq == 1'b1, "R7", "irq with ie", irq, 1);
    wr(2, 3, 0);
    chk({ch_done[2], irq} == 2'b00, "R7", "done clear on ctrl write", {ch_done[2], irq}, 0);

    // R5: ch3 dual, byte, source decrement, destination fixed, no irq
    add_units(3, 32'h0000_3000, 32'h4000_0000, 2, 9'h021, "R5_R4");
    prog(3, 32'h0000_3000, 32'h4000_0000, 2, 9'h021);
    dreq[3] = 1'b1;
    wait_done(3, 200, "R6");
    dreq[3] = 1'b0;
    chk(irq == 1'b0, "R7", "irq masked", irq, 0);
    wr(3, 3, 0);

    // R3: ch0 single, peripheral is destination (reads), byte, increment
    add_units(0, 32'h5000_0010, 32'h0, 2, 9'h015, "R3");
    prog(0, 32'h5000_0010, 32'h0, 2, 9'h015);
    dreq[0] = 1'b1;
    wait_done(0, 200, "R3");
    dreq[0] = 1'b0;

    // R3: ch1 single, peripheral is source (writes), word, dest decrement
    add_units(1, 32'h0, 32'h6000_0100, 3, 9'h18F, "R3");
    prog(1, 32'h0, 32'h6000_0100, 3, 9'h18F);
    dreq[1] = 1'b1;
    wait_done(1, 200, "R3");
    dreq[1] = 1'b0;
    chk(irq == 1'b1, "R7", "irq from ch1", irq, 1);
    wr(0, 3, 0); wr(1, 3, 0);
    chk({ch_done, irq} == '0, "R7", "all flags clear", {ch_done, irq}, 0);

    // R9: single mode on ch2 refused
    prog(2, 32'h7000_0000, 32'h7100_0000, 2, 9'h005);
    chk(ch_err[2] == 1'b1, "R9", "error flag", ch_err, 4);
    dreq[2] = 1'b1;
    repeat (30) @(negedge clk);
    chk({bus_req, ch_done[2]} == 2'b00, "R9", "no start", {bus_req, ch_done[2]}, 0);
    dreq[2] = 1'b0;
    wr(2, 3, 0);
    chk(ch_err[2] == 1'b0, "R7", "error clear on ctrl write", ch_err, 0);

    // R8: ch1 and ch3 request together; ch1 drains first
    add_units(1, 32'h0000_8000, 32'h0000_9000, 2, 9'h051, "R8");
    add_units(3, 32'h0000_A000, 32'h0000_B000, 2, 9'h053, "R8");
    prog(1, 32'h0000_8000, 32'h0000_9000, 2, 9'h051);
    prog(3, 32'h0000_A000, 32'h0000_B000, 2, 9'h053);
    dreq = 4'b1010;
    wait_done(3, 300, "R8");
    chk(ch_done[1] == 1'b1, "R8", "ch1 done", ch_done, 4'b1010);
    dreq = 4'b0000;
    wr(1, 3, 0); wr(3, 3, 0);

    // R6: count of zero runs 2^CNT_W units
    add_units(0, 32'h0000_C000, 32'h0000_D000, 1 << CW, 9'h001, "R6");
    prog(0, 32'h0000_C000, 32'h0000_D000, 0, 9'h001);
    dreq[0] = 1'b1;
    wait_done(0, (1 << CW) * 8 + 100, "R6");
    dreq[0] = 1'b0;
    repeat (10) @(negedge clk);
    chk(bus_req == 1'b0, "R6", "stops after last unit", bus_req, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule